// File: doc/BRIEF.md
# Windowed Crossing-Count Frequency Range Detector

This block sorts a monitored signal into one of eight frequency bands. An external comparator sets its output high while the signal is above a threshold. The block counts how many times that output goes high during a measurement window of fixed length, then hands the tally over as a binary range code. The code drives switched-capacitor or bias-ladder select lines, so a count of k connects k capacitor units.

A start-calibration pulse loads the window length and clears the tally. A window timer on the system clock then counts down while a saturating counter adds up the rising edges of the synchronised comparator output. When the timer expires, both counters stop. The code stays frozen and a valid flag stays high until the next start pulse. One measurement is made per start pulse.

Top module: `xing_band_detector`

## Requirements
- R1: In reset, and in the first cycle after reset is released, `range_valid` is 0 and `range_code` is 0.
- R2: A `start_cal` sampled high while no measurement is running begins a measurement. On the next cycle `range_valid` is 0 and `range_code` is 0, and `win_len` is captured as the window length.
- R3: The window lasts exactly `win_len` clock cycles, and a `win_len` of 0 is treated as 1. `range_valid` goes high at the clock edge `win_len` cycles after the edge that sampled `start_cal`. It is never high while a measurement runs.
- R4: `cmp_in` passes through a two-flop synchroniser. Each 0-to-1 transition of the synchronised level inside the window adds exactly one to the count. A level already high when the measurement starts, and held high, adds nothing.
- R5: The count saturates at 7 and never wraps, so more than seven crossings give code 7.
- R6: Once the window has ended, comparator activity is ignored. `range_code` and `range_valid` hold steady until the next `start_cal`.
- R7: A `start_cal` that arrives while a measurement is running is ignored. The window is neither restarted nor reloaded.
- R8: `range_code` is the plain binary crossing count. Bit 0 selects one capacitor unit, bit 1 selects two and bit 2 selects four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_cal | input | 1 | Start pulse for one measurement |
| cmp_in | input | 1 | Asynchronous comparator output, high while the signal is above the threshold |
| win_len | input | WIN_W | Window length in clock cycles, captured at start |
| range_code | output | 3 | Binary crossing count used as the capacitor/bias select |
| range_valid | output | 1 | High while `range_code` holds a finished measurement |

## Verification
The assertions assume that the comparator output, once synchronised, changes no faster than the clock. They also assume that `start_cal` is a level sampled on the clock, with no further timing rule, since the block must ignore it during a window. The stimulus drives every input at the falling clock edge. It keeps comparator pulses at least two cycles high and two cycles low, and ends each pulse train a few cycles before the window closes, so that the expected count follows directly from the number of pulses. Separate directed cases cover:
- a start pulse issued in the middle of a window;
- a comparator held high across a start pulse;
- comparator pulses after the window has ended;
- a window length of zero.

// File: rtl/xbd_pkg.sv
// Shared types for the crossing-count range detector.
// Assumes: a three-state control flow (idle, measuring, done).
package xbd_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_DONE = 2'd2
    } xbd_state_e;
endpackage

// File: rtl/xbd_edge_sync.sv
// Synchronises an asynchronous level and flags its rising edges.
// Assumes: the input stays stable for at least one clock period after each change.
module xbd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchroniser chain: stage 0 samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each further stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gi] <= 1'b0;
                else        chain_q[gi] <= chain_q[gi-1];
            end
        end
    endgenerate

    // Keeps last cycle's synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/xbd_window_timer.sv
// Down-counter that times the measurement window.
// Assumes: a zero length is widened to one cycle; run is high only while measuring.
module xbd_window_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    input  logic         run_i,
    output logic [W-1:0] remain_o,
    output logic         last_o
);
    logic [W-1:0] remain_q;

    // Load on start, then count down by one each measuring cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                        remain_q <= '0;
        else if (load_i)                   remain_q <= (len_i == '0) ? W'(1) : len_i;
        else if (run_i && remain_q != '0)  remain_q <= remain_q - W'(1);
    end

    assign remain_o = remain_q;
    assign last_o   = run_i && (remain_q == W'(1));
endmodule

// File: rtl/xbd_sat_counter.sv
// Saturating up-counter for the crossing tally.
// Assumes: clear has priority over increment; counting only when enabled.
module xbd_sat_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Clear on start; add one per enabled event; stop at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (clr_i)                               cnt_q <= '0;
        else if (en_i && inc_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/xing_band_detector.sv
// Top level: one-shot windowed count of comparator crossings, output as a range code.
// Assumes: cmp_in is asynchronous; start_cal is sampled on clk; one measurement per start.
module xing_band_detector
    import xbd_pkg::*;
#(
    parameter int WIN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cal,
    input  logic              cmp_in,
    input  logic [WIN_W-1:0]  win_len,
    output logic [CODE_W-1:0] range_code,
    output logic              range_valid
);
    xbd_state_e       state_q;
    logic             meas_busy;
    logic             start_take;
    logic             cross_rise;
    logic             win_last;
    logic [WIN_W-1:0] win_remain;

    assign meas_busy  = (state_q == ST_MEAS);
    assign start_take = start_cal && !meas_busy;

    xbd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_in),
        .rise_o   (cross_rise)
    );

    xbd_window_timer #(.W(WIN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (start_take),
        .len_i    (win_len),
        .run_i    (meas_busy),
        .remain_o (win_remain),
        .last_o   (win_last)
    );

    xbd_sat_counter #(.W(CODE_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_take),
        .en_i  (meas_busy),
        .inc_i (cross_rise),
        .cnt_o (range_code)
    );

    // Control flow: idle or done -> measuring on start; measuring -> done at window end.
    always_ff @(posedge clk) begin
        if (!rst_n)          state_q <= ST_IDLE;
        else if (start_take) state_q <= ST_MEAS;
        else if (win_last)   state_q <= ST_DONE;
    end

    assign range_valid = (state_q == ST_DONE);
endmodule

// File: rtl/xbd_checker.sv
// Property checker for xing_band_detector, attached by bind.
// Assumes: it observes the top ports plus the busy flag and the remaining window count.
module xbd_checker #(
    parameter int WIN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_cal,
    input logic             busy,
    input logic [WIN_W-1:0] remain,
    input logic [2:0]       range_code,
    input logic             range_valid
);
    // R2: a start outside a measurement clears the result and begins measuring.
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cal && !busy) |=> (busy && !range_valid && range_code == 3'd0));

    // R3: valid and measuring are never high together.
    assert_valid_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && range_valid));

    // R4: the tally moves by at most one per measuring cycle.
    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start_cal) |=> (range_code == $past(range_code) ||
                                  range_code == $past(range_code) + 3'd1));

    // R5: once at the top value, the tally stays there while measuring.
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && range_code == 3'd7) |=> (range_code == 3'd7));

    // R6: a finished result holds until the next start.
    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (range_valid && !start_cal) |=> (range_valid && $stable(range_code)));

    // R7: a start during a measurement does not reload the window.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_cal && remain > WIN_W'(1)) |=> (remain == $past(remain) - WIN_W'(1)));
endmodule

bind xing_band_detector xbd_checker #(.WIN_W(WIN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_cal   (start_cal),
    .busy        (meas_busy),
    .remain      (win_remain),
    .range_code  (range_code),
    .range_valid (range_valid)
);

// File: tb/xing_band_detector_tb.sv
module xing_band_detector_tb;
    localparam int WIN_W = 16;
    localparam int NVEC  = 7;
    // Each row: window length, number of comparator pulses, expected code.
    localparam int VEC [0:NVEC-1][0:2] = '{
        '{64, 0, 0}, '{64, 1, 1}, '{64, 3, 3}, '{64, 7, 7},
        '{64, 9, 7}, '{100, 5, 5}, '{1, 0, 0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_cal = 1'b0;
    logic             cmp_in = 1'b0;
    logic [WIN_W-1:0] win_len = '0;
    logic [2:0]       range_code;
    logic             range_valid;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [2:0] held_code;

    always #2 clk = ~clk;

    xing_band_detector #(.WIN_W(WIN_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_cal   (start_cal),
        .cmp_in      (cmp_in),
        .win_len     (win_len),
        .range_code  (range_code),
        .range_valid (range_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start a window, drive np pulses (2 high, 2 low), and check timing and code.
    task automatic run_window(input int win, input int np, input int exp, input string req);
        @(negedge clk); start_cal = 1'b1; win_len = WIN_W'(win);
        @(negedge clk); start_cal = 1'b0;
        check(range_code == 3'd0 && !range_valid, "R2", {range_valid, range_code}, 0);
        for (int k = 0; k < win; k++) begin
            cmp_in = (k < 4*np) && (k % 4 < 2);
            if (k == win - 1) check(!range_valid, "R3", range_valid, 0);
            @(negedge clk);
        end
        cmp_in = 1'b0;
        check(range_valid, "R3", range_valid, 1);
        check(range_code == 3'(exp), req, range_code, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!range_valid && range_code == 3'd0, "R1", {range_valid, range_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!range_valid && range_code == 3'd0, "R1", {range_valid, range_code}, 0);

        // Table walk: R4 counts, R5 saturation, R8 binary code.
        for (int v = 0; v < NVEC; v++) begin
            run_window(VEC[v][0], VEC[v][1], VEC[v][2],
                       (VEC[v][2] == 7) ? "R5" : ((VEC[v][1] == 5) ? "R8" : "R4"));
        end

        // R6: pulses after the window ends leave the result untouched.
        run_window(40, 2, 2, "R4");
        held_code = range_code;
        for (int k = 0; k < 24; k++) begin
            cmp_in = (k % 4 < 2);
            @(negedge clk);
        end
        cmp_in = 1'b0;
        repeat (4) @(negedge clk);
        check(range_valid && range_code == held_code, "R6", range_code, held_code);

        // R7: a start in mid-window neither restarts nor shortens it.
        @(negedge clk); start_cal = 1'b1; win_len = WIN_W'(40);
        @(negedge clk); start_cal = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (k == 10) begin start_cal = 1'b1; win_len = WIN_W'(5); end
            else         start_cal = 1'b0;
            if (k == 20) check(!range_valid, "R7", range_valid, 0);
            if (k == 39) check(!range_valid, "R7", range_valid, 0);
            @(negedge clk);
        end
        start_cal = 1'b0;
        check(range_valid, "R7", range_valid, 1);

        // R4: a level held high across the start is not a crossing.
        cmp_in = 1'b1;
        repeat (5) @(negedge clk);
        start_cal = 1'b1; win_len = WIN_W'(20);
        @(negedge clk); start_cal = 1'b0;
        repeat (20) @(negedge clk);
        check(range_valid && range_code == 3'd0, "R4", range_code, 0);
        cmp_in = 1'b0;
        repeat (3) @(negedge clk);

        // R3: a zero length behaves as a one-cycle window.
        start_cal = 1'b1; win_len = '0;
        @(negedge clk); start_cal = 1'b0;
        check(!range_valid, "R3", range_valid, 0);
        @(negedge clk);
        check(range_valid, "R3", range_valid, 1);

        // R1: reset from the done state clears the result.
        rst_n = 1'b0;
        @(negedge clk);
        check(!range_valid && range_code == 3'd0, "R1", {range_valid, range_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule